// File: doc/BRIEF.md
# Angle Word Bus Port

This block connects an internal angle up/down counter to a 16-line three-state parallel data bus. The counter raises an update strobe whenever it steps. The block answers each strobe with a converter-busy pulse of fixed length. When that pulse ends, the block copies the counter value into an output latch, keeping only as many of the top bits as the selected resolution allows. All lower lines read as zero.

An active-low inhibit input lets a reader freeze the presented word so that it can read the word safely across both bus halves. If inhibit falls while an update is still running, that update is allowed to land first, so the latch never holds a half-updated value. Two active-low byte enables control the bus drivers. One drives lines 1–8, the upper byte, which carries the MSB. The other drives lines 9–16, the lower byte. A disabled byte is released to high impedance. The enables have no effect on what the latch holds.

Top module: `angle_bus_port`

## Requirements
- R1: The resolution code `res_sel` picks the number of kept bits: 0 keeps 10, 1 keeps 12, 2 keeps 14 and 3 keeps 16. Kept bits are the top bits of `count_in`. `bus[15]` is line 1, the MSB, in natural binary. Every bus line below the kept bits reads 0.
- R2: A strobe on `upd_req` while idle raises `busy` on the next clock. `busy` then stays high for exactly BUSY_CYC clocks. The default is 100 clocks, which is 0.5 µs at 200 MHz.
- R3: A strobe that arrives while `busy` is high is ignored. It neither restarts nor lengthens the pulse.
- R4: While `inhibit_n` is high, the latch captures `count_in` and `res_sel` on the clock edge after the one where `busy` falls.
- R5: When `inhibit_n` is low and no update is running, the latched word is frozen. Later updates still pulse `busy` but do not change the word.
- R6: When `inhibit_n` falls while `busy` is high, the running update still loads the latch. After that, the word stays frozen.
- R7: After `inhibit_n` returns high, the next completed update loads the latch again.
- R8: `hi_en_n` low drives the upper byte `bus[15:8]` with the latched word one clock later. `hi_en_n` high releases those lines to high impedance one clock later.
- R9: `lo_en_n` controls `bus[7:0]` in the same way, independently of `hi_en_n`.
- R10: The byte enables do not affect the latch. An update that completes while both bytes are released appears on the bus once the bytes are enabled again.
- R11: After reset, `busy` is low, the latch holds zero, no update is pending and both bytes are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_req | input | 1 | Counter update strobe |
| count_in | input | 16 | Current angle count, MSB first |
| res_sel | input | 2 | Resolution code |
| inhibit_n | input | 1 | Active-low freeze of the presented word |
| hi_en_n | input | 1 | Active-low enable of bus[15:8] |
| lo_en_n | input | 1 | Active-low enable of bus[7:0] |
| busy | output | 1 | Converter-busy pulse |
| bus | inout | 16 | Three-state parallel data bus |

## Verification
`busy` rises one clock after a strobe is sampled and falls BUSY_CYC clocks later. The new word sits in the latch one clock after that fall. A byte enable reaches the bus pins one clock after it is sampled, so a changed word is due on the bus BUSY_CYC+2 clocks after the strobe. The bench's behavioural model advances on each rising edge using those same delays, and both `busy` and the bus lines, with pull-ups, are compared on every falling edge. The directed checks sample three or more clocks after each due point and compare against hard-coded words.

// File: rtl/angle_bus_pkg.sv
package angle_bus_pkg;

  typedef enum logic [1:0] {
    RES_LOW  = 2'd0,
    RES_MID  = 2'd1,
    RES_HIGH = 2'd2,
    RES_FULL = 2'd3
  } res_code_e;

  function automatic int unsigned kept_bits(input logic [1:0] code,
                                            input int unsigned min_bits,
                                            input int unsigned step);
    return min_bits + step * int'(code);
  endfunction

endpackage

// File: rtl/busy_timer.sv
module busy_timer #(
  parameter int unsigned CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          cnt_q  <= CW'(CYC - 1);
        end
      end else if (cnt_q == '0) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  logic [CW:0] ck_len;
  always_ff @(posedge clk) begin
    if (rst) ck_len <= '0;
    else     ck_len <= busy_q ? ck_len + 1'b1 : '0;
  end

  p_busy_source_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(start_i));

  p_busy_length_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> (ck_len == (CW+1)'(CYC)));

  p_busy_cap_r2: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (ck_len < (CW+1)'(CYC)));

endmodule

// File: rtl/word_latch.sv
module word_latch
  import angle_bus_pkg::*;
#(
  parameter int unsigned W        = 16,
  parameter int unsigned MIN_BITS = 10,
  parameter int unsigned STEP     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         done_i,
  input  logic         busy_i,
  input  logic         inhibit_n_i,
  input  logic [W-1:0] count_i,
  input  logic [1:0]   res_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] mask;
  logic [W-1:0] word_q;
  logic         freeze_q;
  int unsigned  keep;

  always_comb begin
    keep = kept_bits(res_i, MIN_BITS, STEP);
    for (int i = 0; i < int'(W); i++) begin
      mask[i] = (i >= int'(W) - int'(keep));
    end
  end

  // Freeze may only be newly set while no update is running;
  // a running update can still be released by inhibit going high.
  always_ff @(posedge clk) begin
    if (rst) begin
      freeze_q <= 1'b0;
    end else if (!busy_i) begin
      freeze_q <= ~inhibit_n_i;
    end else begin
      freeze_q <= freeze_q & ~inhibit_n_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (done_i && !freeze_q) begin
      word_q <= count_i & mask;
    end
  end

  assign word_o = word_q;

  p_frozen_hold_r5: assert property (@(posedge clk) disable iff (rst)
    freeze_q |=> $stable(word_q));

  p_load_after_done_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(word_q) |-> $past(done_i));

  p_zero_fill_r1: assert property (@(posedge clk) disable iff (rst)
    (done_i && !freeze_q) |=> ((word_q & ~$past(mask)) == '0));

endmodule

// File: rtl/bus_driver.sv
module bus_driver #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hi_en_n_i,
  input  logic         lo_en_n_i,
  input  logic [W-1:0] word_i,
  inout  wire  [W-1:0] bus_io
);
  localparam int unsigned H = W / 2;

  logic [1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 2'b00;
    else     en_q <= {~hi_en_n_i, ~lo_en_n_i};
  end

  for (genvar g = 0; g < 2; g++) begin : g_half
    assign bus_io[g*H +: H] = en_q[g] ? word_i[g*H +: H] : {H{1'bz}};
  end

endmodule

// File: rtl/angle_bus_port.sv
module angle_bus_port
  import angle_bus_pkg::*;
#(
  parameter int unsigned W        = 16,
  parameter int unsigned MIN_BITS = 10,
  parameter int unsigned STEP     = 2,
  parameter int unsigned CLK_HZ   = 200_000_000,
  parameter int unsigned BUSY_NS  = 500
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd_req,
  input  logic [W-1:0] count_in,
  input  logic [1:0]   res_sel,
  input  logic         inhibit_n,
  input  logic         hi_en_n,
  input  logic         lo_en_n,
  output logic         busy,
  inout  wire  [W-1:0] bus
);
  localparam int unsigned BUSY_CYC_RAW = (CLK_HZ / 1_000_000) * BUSY_NS / 1000;
  localparam int unsigned BUSY_CYC     = (BUSY_CYC_RAW < 1) ? 1 : BUSY_CYC_RAW;

  logic         busy_w;
  logic         done_w;
  logic [W-1:0] word_w;

  busy_timer #(.CYC(BUSY_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start_i (upd_req),
    .busy_o  (busy_w),
    .done_o  (done_w)
  );

  word_latch #(.W(W), .MIN_BITS(MIN_BITS), .STEP(STEP)) u_latch (
    .clk         (clk),
    .rst         (rst),
    .done_i      (done_w),
    .busy_i      (busy_w),
    .inhibit_n_i (inhibit_n),
    .count_i     (count_in),
    .res_i       (res_sel),
    .word_o      (word_w)
  );

  bus_driver #(.W(W)) u_drv (
    .clk       (clk),
    .rst       (rst),
    .hi_en_n_i (hi_en_n),
    .lo_en_n_i (lo_en_n),
    .word_i    (word_w),
    .bus_io    (bus)
  );

  assign busy = busy_w;

  p_word_quiet_when_busy_r4: assert property (@(posedge clk) disable iff (rst)
    busy_w |=> $stable(word_w));

endmodule

// File: tb/angle_bus_port_bench.sv
module angle_bus_port_bench;
  localparam int N = 100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_req = 1'b0;
  logic [15:0] count_in = '0;
  logic [1:0]  res_sel = 2'd3;
  logic        inhibit_n = 1'b1;
  logic        hi_en_n = 1'b1;
  logic        lo_en_n = 1'b1;
  logic        busy;
  wire  [15:0] bus;

  for (genvar i = 0; i < 16; i++) begin : g_pu
    pullup (bus[i]);
  end

  angle_bus_port u_angle_bus_port (
    .clk(clk), .rst(rst), .upd_req(upd_req), .count_in(count_in),
    .res_sel(res_sel), .inhibit_n(inhibit_n), .hi_en_n(hi_en_n),
    .lo_en_n(lo_en_n), .busy(busy), .bus(bus)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit ended  = 0;

  // Behavioural reference model
  int          m_left = 0;
  bit          m_busy = 0, m_done = 0, m_freeze = 0, m_hi = 0, m_lo = 0;
  logic [15:0] m_word = '0;

  function automatic logic [15:0] trim(input logic [15:0] v, input logic [1:0] r);
    int keep = 10 + 2 * int'(r);
    logic [15:0] o = '0;
    for (int i = 15; i >= 16 - keep; i--) o[i] = v[i];
    return o;
  endfunction

  always @(posedge clk) begin
    bit b, d, f;
    int left;
    cyc++;
    if (rst) begin
      m_left = 0; m_busy = 0; m_done = 0; m_freeze = 0;
      m_word = '0; m_hi = 0; m_lo = 0;
    end else begin
      b = m_busy; d = m_done; f = m_freeze; left = m_left;
      if (d && !f) m_word = trim(count_in, res_sel);
      m_freeze = b ? (f && !inhibit_n) : !inhibit_n;
      m_done = 0;
      if (!b) begin
        if (upd_req) begin m_busy = 1; m_left = N; end
      end else begin
        m_left = left - 1;
        if (m_left == 0) begin m_busy = 0; m_done = 1; end
      end
      m_hi = !hi_en_n;
      m_lo = !lo_en_n;
    end
    if (cyc == 60000 && !ended) begin
      ended = 1;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    logic [15:0] exp_bus;
    if (!rst) begin
      exp_bus = {m_hi ? m_word[15:8] : 8'hFF, m_lo ? m_word[7:0] : 8'hFF};
      checks++;
      if (busy !== m_busy) begin
        errors++;
        $display("FAIL R2 per-cycle busy: actual %0b expected %0b", busy, m_busy);
      end
      checks++;
      if (bus !== exp_bus) begin
        errors++;
        $display("FAIL R4 R8 R9 per-cycle bus: actual %h expected %h", bus, exp_bus);
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic strobe();
    upd_req = 1'b1;
    @(negedge clk);
    upd_req = 1'b0;
  endtask

  task automatic update(input logic [15:0] v, input logic [1:0] r);
    count_in = v; res_sel = r;
    strobe();
    repeat (N + 3) @(negedge clk);
  endtask

  initial begin
    int len;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset busy", {15'd0, busy}, 16'h0000);
    chk("R11 reset bus released", bus, 16'hFFFF);
    hi_en_n = 1'b0; lo_en_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R11 reset word zero", bus, 16'h0000);

    // R2 pulse length
    count_in = 16'h5A5B; res_sel = 2'd3;
    strobe();
    len = 0;
    while (busy && len < 1000) begin len++; @(negedge clk); end
    chk("R2 busy width", 16'(len), 16'(N));
    repeat (3) @(negedge clk);
    chk("R4 full resolution word", bus, 16'h5A5B);

    update(16'h5A5B, 2'd0);
    chk("R1 10-bit zero fill", bus, 16'h5A40);
    update(16'h5A5B, 2'd1);
    chk("R1 12-bit zero fill", bus, 16'h5A50);
    update(16'h5A5B, 2'd2);
    chk("R1 14-bit zero fill", bus, 16'h5A58);
    update(16'hC3E7, 2'd3);
    chk("R4 new word", bus, 16'hC3E7);

    // R3 retrigger while busy
    count_in = 16'h1234; res_sel = 2'd3;
    strobe();
    len = 1;
    repeat (40) begin @(negedge clk); len++; end
    upd_req = 1'b1; @(negedge clk); upd_req = 1'b0; len++;
    while (busy && len < 1000) begin len++; @(negedge clk); end
    chk("R3 retrigger ignored width", 16'(len - 1), 16'(N));
    repeat (3) @(negedge clk);
    chk("R3 word after retrigger", bus, 16'h1234);

    // R5 freeze while idle
    inhibit_n = 1'b0;
    @(negedge clk);
    update(16'hFFFF, 2'd3);
    chk("R5 frozen word", bus, 16'h1234);

    // R7 release
    inhibit_n = 1'b1;
    @(negedge clk);
    update(16'h8001, 2'd3);
    chk("R7 resumes after release", bus, 16'h8001);

    // R6 inhibit falls mid update
    count_in = 16'h0F0F; res_sel = 2'd3;
    strobe();
    repeat (10) @(negedge clk);
    inhibit_n = 1'b0;
    repeat (N) @(negedge clk);
    chk("R6 running update lands", bus, 16'h0F0F);
    update(16'h7777, 2'd3);
    chk("R6 frozen afterwards", bus, 16'h0F0F);
    inhibit_n = 1'b1;
    @(negedge clk);

    // R8 R9 byte enables
    hi_en_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R8 upper released", bus, 16'hFF0F);
    hi_en_n = 1'b0; lo_en_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R9 lower released", bus, 16'h0FFF);

    // R10 enables do not block the latch
    hi_en_n = 1'b1;
    @(negedge clk);
    update(16'hBEEF, 2'd3);
    chk("R10 both released", bus, 16'hFFFF);
    hi_en_n = 1'b0; lo_en_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R10 word loaded while released", bus, 16'hBEEF);

    repeat (5) @(negedge clk);
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule